// File: doc/BRIEF.md
# Receive Descriptor Completion Checker

This block sits beside a receive engine that writes a 32-bit command/status word back into each descriptor it finishes. When that word is presented with a valid strobe, the block decides whether the frame may be passed to the upper layer. It reports the payload length with the trailing CRC removed and holds that verdict until the consumer takes it.

The consumer acknowledges a held verdict with a consume strobe. On that strobe the block steps a four-entry ring index, wrapping at the end. It also produces the word that re-arms the descriptor for the receive engine, and pulses a receive-enable request so that an engine that stalled on a full ring starts again. A descriptor is re-armed whether the frame was good or bad. Descriptor fetch, memory traffic and address filtering are outside this block.

Top module: `rxdesc_checker`

## Requirements
- R1: After reset, verdict_valid, frame_good, payload_len, ring_idx, rx_enable_req and rearm_word are all zero.
- R2: A status word with bit 31 (ownership) set, presented with stat_valid, raises verdict_valid on the next clock. The verdict stays held until it is consumed or replaced by a later stat_valid.
- R3: A status word with bit 31 clear, presented with stat_valid, leaves verdict_valid, frame_good and payload_len at zero on the next clock, and ring_idx does not change.
- R4: frame_good is 1 only when bit 27 (packet good) is set, bit 30 (more fragments) is clear, bit 22 (overlong) is clear, and the size field is at least 4. Every other bit is ignored.
- R5: payload_len is the size field in bits 11:0 minus 4. It is reported for good and bad frames alike.
- R6: A size field below 4 gives frame_good = 0 and payload_len = 0.
- R7: A consume while verdict_valid is 1 advances ring_idx by one on the next clock, with 3 wrapping to 0. It also clears verdict_valid, unless a new word is loaded in the same cycle.
- R8: A consume while verdict_valid is 0 is ignored: ring_idx, rx_enable_req and rearm_word do not change.
- R9: An accepted consume sets rearm_word to 32'h0000_0600 on the next clock: size 1536 and bit 31 clear. This happens whether the verdict was good or bad.
- R10: rx_enable_req is a one-cycle pulse on the clock after each accepted consume, and is 0 otherwise.
- R11: When stat_valid and an accepted consume fall in the same cycle, the consume acts on the held verdict and the new word's verdict is then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_word | input | 32 | Command/status word written back by the receive engine |
| stat_valid | input | 1 | stat_word is valid this cycle |
| consume | input | 1 | Consumer takes the held verdict |
| verdict_valid | output | 1 | A verdict for an owned descriptor is held |
| frame_good | output | 1 | Held frame may be passed up |
| payload_len | output | 12 | Held payload length, CRC removed |
| ring_idx | output | 2 | Current descriptor ring slot |
| rearm_word | output | 32 | Status word to write back on re-arm |
| rx_enable_req | output | 1 | Single-cycle receive restart request |

## Verification
The stimulus sets each of the three status flags alone and in combination, so a decoder that checked only the good bit would accept frames that have more fragments or are overlong. It also sets bits outside the three flags, to catch a decoder that compares too many bits. Size fields of 3, 4 and 4095 probe the CRC subtraction: a design without the guard would wrap 3 to a length near 4095, and one that compares with the wrong sign would reject a good frame of size 4.

Ten consumes in a row take the index past 3 twice, so an index that saturates instead of wrapping shows up. Stray consumes with no verdict held, words whose ownership bit is clear, and a load that falls in the same cycle as a consume catch a design that steps the index or re-arms the descriptor without cause, or that drops the new verdict.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  // Field positions the receive engine writes; the decoder depends on them.
  localparam int OWN_BIT  = 31;
  localparam int MORE_BIT = 30;
  localparam int OK_BIT   = 27;
  localparam int LONG_BIT = 22;
  localparam int SIZE_W   = 12;
  localparam int WORD_W   = 32;

  typedef logic [SIZE_W-1:0] size_t;

  typedef struct packed {
    logic  owned;
    logic  good;
    size_t len;
  } verdict_t;

  // Accept only the exact flag pattern: good set, more clear, long clear.
  function automatic logic flags_accept(input logic more_f, input logic ok_f,
                                        input logic long_f);
    return ({more_f, ok_f, long_f} == 3'b010);
  endfunction

  // Remove the CRC bytes; saturate at zero when the size is too small.
  function automatic size_t strip_crc(input size_t size, input size_t crc);
    return (size >= crc) ? size_t'(size - crc) : '0;
  endfunction

  // Word that hands a descriptor back to the engine: ownership clear.
  function automatic logic [WORD_W-1:0] rearm_value(input size_t buf_bytes);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SIZE_W-1:0] = buf_bytes;
    w[OWN_BIT] = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/rxd_status_decode.sv
module rxd_status_decode
  import rxd_pkg::*;
#(
  parameter int CRC_BYTES = 4
) (
  input  logic [WORD_W-1:0] word_i,
  output verdict_t          verdict_o
);
  localparam size_t CRC_SZ = size_t'(CRC_BYTES);

  size_t size_field;
  logic  flags_ok;
  logic  size_ok;

  always_comb begin
    size_field      = word_i[SIZE_W-1:0];
    flags_ok        = flags_accept(word_i[MORE_BIT], word_i[OK_BIT], word_i[LONG_BIT]);
    size_ok         = (size_field >= CRC_SZ);
    verdict_o.owned = word_i[OWN_BIT];
    verdict_o.good  = word_i[OWN_BIT] & flags_ok & size_ok;
    verdict_o.len   = word_i[OWN_BIT] ? strip_crc(size_field, CRC_SZ) : '0;
  end
endmodule

// File: rtl/rxd_verdict_hold.sv
module rxd_verdict_hold
  import rxd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  verdict_t verdict_i,
  input  logic     release_i,
  output logic     valid_o,
  output logic     good_o,
  output size_t    len_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      good_o  <= 1'b0;
      len_o   <= '0;
    end else if (load_i) begin
      valid_o <= verdict_i.owned;
      good_o  <= verdict_i.good;
      len_o   <= verdict_i.len;
    end else if (release_i) begin
      valid_o <= 1'b0;
      good_o  <= 1'b0;
      len_o   <= '0;
    end
  end
endmodule

// File: rtl/rxd_ring_index.sv
module rxd_ring_index #(
  parameter int RING_DEPTH = 4,
  localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_DEPTH - 1);

  logic [IDX_W-1:0] idx_next;

  generate
    if ((1 << IDX_W) == RING_DEPTH) begin : g_pow2
      // Power-of-two depth: natural rollover performs the wrap.
      always_comb idx_next = idx_o + 1'b1;
    end else begin : g_cmp
      always_comb idx_next = (idx_o == LAST) ? '0 : idx_o + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         idx_o <= '0;
    else if (advance_i) idx_o <= idx_next;
  end
endmodule

// File: rtl/rxd_rearm_gen.sv
module rxd_rearm_gen
  import rxd_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  output logic [WORD_W-1:0] rearm_o,
  output logic              restart_o
);
  localparam logic [WORD_W-1:0] REARM = rearm_value(size_t'(BUF_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rearm_o   <= '0;
      restart_o <= 1'b0;
    end else begin
      restart_o <= fire_i;
      if (fire_i) rearm_o <= REARM;
    end
  end
endmodule

// File: rtl/rxdesc_checker.sv
module rxdesc_checker
  import rxd_pkg::*;
#(
  parameter int RING_DEPTH = 4,
  parameter int CRC_BYTES  = 4,
  parameter int BUF_BYTES  = 1536,
  localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       stat_word,
  input  logic              stat_valid,
  input  logic              consume,
  output logic              verdict_valid,
  output logic              frame_good,
  output logic [11:0]       payload_len,
  output logic [IDX_W-1:0]  ring_idx,
  output logic [31:0]       rearm_word,
  output logic              rx_enable_req
);
  verdict_t decoded;
  logic     consume_fire;   // accepted consume: a verdict is held

  assign consume_fire = consume & verdict_valid;

  rxd_status_decode #(.CRC_BYTES(CRC_BYTES)) u_decode (
    .word_i    (stat_word),
    .verdict_o (decoded)
  );

  rxd_verdict_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (stat_valid),
    .verdict_i (decoded),
    .release_i (consume_fire),
    .valid_o   (verdict_valid),
    .good_o    (frame_good),
    .len_o     (payload_len)
  );

  rxd_ring_index #(.RING_DEPTH(RING_DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (consume_fire),
    .idx_o     (ring_idx)
  );

  rxd_rearm_gen #(.BUF_BYTES(BUF_BYTES)) u_rearm (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (consume_fire),
    .rearm_o   (rearm_word),
    .restart_o (rx_enable_req)
  );
endmodule

// File: rtl/rxd_checker_sva.sv
module rxd_checker_sva #(
  parameter int RING_DEPTH = 4,
  parameter int CRC_BYTES  = 4,
  parameter int BUF_BYTES  = 1536,
  localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      stat_word,
  input logic             stat_valid,
  input logic             consume,
  input logic             verdict_valid,
  input logic             frame_good,
  input logic [11:0]      payload_len,
  input logic [IDX_W-1:0] ring_idx,
  input logic [31:0]      rearm_word,
  input logic             rx_enable_req,
  input logic             consume_fire
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_DEPTH - 1);

  AST_OWNED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_word[31] |=> verdict_valid);                          // R2
  AST_UNOWNED_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_word[31] |=> !verdict_valid && !frame_good);         // R3
  AST_GOOD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> verdict_valid);                                           // R4
  AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_word[11:0] < 12'(CRC_BYTES)
      |=> !frame_good && payload_len == 12'd0);                              // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    consume_fire && ring_idx != LAST |=> ring_idx == $past(ring_idx) + 1'b1); // R7
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    consume_fire && ring_idx == LAST |=> ring_idx == '0);                    // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !consume_fire |=> $stable(ring_idx) && $stable(rearm_word));             // R8
  AST_REARM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    consume_fire |=> rearm_word == 32'(BUF_BYTES) && !rearm_word[31]);       // R9
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    consume_fire |=> rx_enable_req);                                         // R10
  AST_REQ_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !(consume && verdict_valid) |=> !rx_enable_req);                         // R10
endmodule

bind rxdesc_checker rxd_checker_sva #(
  .RING_DEPTH(RING_DEPTH), .CRC_BYTES(CRC_BYTES), .BUF_BYTES(BUF_BYTES)
) u_sva (
  .clk(clk), .rst_n(rst_n), .stat_word(stat_word), .stat_valid(stat_valid),
  .consume(consume), .verdict_valid(verdict_valid), .frame_good(frame_good),
  .payload_len(payload_len), .ring_idx(ring_idx), .rearm_word(rearm_word),
  .rx_enable_req(rx_enable_req), .consume_fire(consume_fire)
);

// File: tb/rxdesc_checker_tb.sv
module rxdesc_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] stat_word = '0;
  logic        stat_valid = 1'b0;
  logic        consume = 1'b0;
  logic        verdict_valid, frame_good, rx_enable_req;
  logic [11:0] payload_len;
  logic [1:0]  ring_idx;
  logic [31:0] rearm_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [1:0] exp_idx = '0;

  always #4 clk = ~clk;  // 125 MHz

  rxdesc_checker u_dut (
    .clk(clk), .rst_n(rst_n), .stat_word(stat_word), .stat_valid(stat_valid),
    .consume(consume), .verdict_valid(verdict_valid), .frame_good(frame_good),
    .payload_len(payload_len), .ring_idx(ring_idx), .rearm_word(rearm_word),
    .rx_enable_req(rx_enable_req)
  );

  // {status word, expected good, expected length}
  localparam int NV = 10;
  localparam logic [44:0] VEC [NV] = '{
    {32'h8800_0040, 1'b1, 12'h03C},
    {32'h8800_05EE, 1'b1, 12'h5EA},
    {32'hC800_0100, 1'b0, 12'h0FC},
    {32'h8840_0600, 1'b0, 12'h5FC},
    {32'h8000_0040, 1'b0, 12'h03C},
    {32'h8800_0004, 1'b1, 12'h000},
    {32'h8800_0003, 1'b0, 12'h000},
    {32'h8800_0FFF, 1'b1, 12'hFFB},
    {32'h8FBF_F123, 1'b1, 12'h11F},
    {32'hC840_0010, 1'b0, 12'h00C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [31:0] w);
    stat_word = w; stat_valid = 1'b1;
    @(negedge clk);
    stat_valid = 1'b0;
  endtask

  task automatic do_consume();
    consume = 1'b1;
    @(negedge clk);
    consume = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 verdict_valid", 32'(verdict_valid), 0);
    chk("R1 frame_good", 32'(frame_good), 0);
    chk("R1 payload_len", 32'(payload_len), 0);
    chk("R1 ring_idx", 32'(ring_idx), 0);
    chk("R1 rearm_word", rearm_word, 0);
    chk("R1 rx_enable_req", 32'(rx_enable_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load_word(VEC[i][44:13]);
      chk("R2 verdict_valid", 32'(verdict_valid), 1);
      chk("R4 frame_good", 32'(frame_good), 32'(VEC[i][12]));
      chk("R5/R6 payload_len", 32'(payload_len), 32'(VEC[i][11:0]));
      do_consume();
      exp_idx = exp_idx + 1'b1;
      chk("R7 ring_idx", 32'(ring_idx), 32'(exp_idx));
      chk("R7 verdict cleared", 32'(verdict_valid), 0);
      chk("R9 rearm_word", rearm_word, 32'h0000_0600);
      chk("R10 rx_enable_req", 32'(rx_enable_req), 1);
      @(negedge clk);
      chk("R10 pulse ends", 32'(rx_enable_req), 0);
    end

    // R8: consume with nothing held
    do_consume();
    chk("R8 ring_idx", 32'(ring_idx), 32'(exp_idx));
    chk("R8 rx_enable_req", 32'(rx_enable_req), 0);

    // R3: ownership clear replaces a held verdict with none
    load_word(32'h8800_0040);
    load_word(32'h0800_0040);
    chk("R3 verdict_valid", 32'(verdict_valid), 0);
    chk("R3 frame_good", 32'(frame_good), 0);
    chk("R3 payload_len", 32'(payload_len), 0);
    do_consume();
    chk("R3 ring_idx", 32'(ring_idx), 32'(exp_idx));
    chk("R3 rx_enable_req", 32'(rx_enable_req), 0);

    // R2: later word replaces held verdict
    load_word(32'h8800_0040);
    load_word(32'hC800_0080);
    chk("R2 replaced good", 32'(frame_good), 0);
    chk("R2 replaced len", 32'(payload_len), 32'h07C);

    // R11: new word and consume in the same cycle
    stat_word = 32'h8800_0020; stat_valid = 1'b1; consume = 1'b1;
    @(negedge clk);
    stat_valid = 1'b0; consume = 1'b0;
    exp_idx = exp_idx + 1'b1;
    chk("R11 ring_idx", 32'(ring_idx), 32'(exp_idx));
    chk("R11 rx_enable_req", 32'(rx_enable_req), 1);
    chk("R11 verdict_valid", 32'(verdict_valid), 1);
    chk("R11 frame_good", 32'(frame_good), 1);
    chk("R11 payload_len", 32'(payload_len), 32'h01C);

    // R9: re-arm also after a bad verdict
    load_word(32'h8840_0100);
    do_consume();
    exp_idx = exp_idx + 1'b1;
    chk("R9 rearm after bad", rearm_word, 32'h0000_0600);
    chk("R7 ring_idx after bad", 32'(ring_idx), 32'(exp_idx));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule